// File: doc/BRIEF.md
# Condition-field mask predicate unit

This unit moves predicate information between a bank of eight 4-bit condition fields and a 64-bit integer value. It also combines condition fields with one another. Each operation is steered by a 4-bit mask and a 4-bit mode, so that it can act on any subset of a field's bits in one step. A classic condition-logic operation works on one bit at a time.

Two select bits choose the operation:
- Reduce a source field into a 0/1 integer.
- Expand the low bit of an integer into a destination field.
- Compare a source field against the mode into a destination field.
- Reduce the mode comparison of a field into one condition bit anywhere in the bank.

The integer-result operation can also rewrite field 0 from a signed analysis of its result. That analysis copies a sticky overflow flag into the overflow position.

The unit holds its own condition bank and shows the whole bank on an output. Results are registered: they appear one clock after a valid strobe. Any write to the bank lands on that same edge, so the next operation already sees it.

Top module: `cond_mask_pred`

## Requirements
- R1: After reset the condition bank (`crOut`) is all zero, and `outValid`, `outIntWe`, `outInt` and `outDst` are all zero.
- R2: Registered result stage.
  - `outValid` is high exactly one clock after a cycle with `inValid` high. In that clock `outDst` equals the `dstAddr` given with the strobe.
  - When `outValid` is low, `outDst` is zero.
  - A cycle with `inValid` low leaves `crOut` unchanged, whatever the other inputs are.
- R3: With `opSel`=2'b00 the unit reduces field `srcField` into an integer. It reduces only the bits whose mask bit is 1.
  - `redOp`=00 gives AND (1 if no bit is selected).
  - `redOp`=01 gives OR.
  - `redOp`=10 gives XOR.
  - `redOp`=11 gives 0.
  - The 0/1 value appears on `outInt` with `outIntWe` high. On every other cycle `outInt` is zero and `outIntWe` is low.
- R4: With `opSel`=2'b01, destination field `dstAddr[2:0]` becomes `mask & ~(mode ^ {4{srcInt[0]}})`. Masked-off positions are written 0.
- R5: With `opSel`=2'b10, destination field `dstAddr[2:0]` becomes `mask & ~(mode ^ F)`, where F is field `srcField` read before the write.
- R6: With `opSel`=2'b11, c = `mask & ~(mode ^ F)`.
  - Condition bit `dstAddr` (0..31) becomes OR of the four bits of c when `anyMode`=1, and AND of the four bits when `anyMode`=0.
  - No other bit changes.
- R7: When `recordEn`=1 with `opSel`=2'b00, field 0 becomes {LT,GT,EQ,`stickyOv`}.
  - The integer result is taken as signed 64-bit.
  - Exactly one of LT, GT and EQ is set.
  - Other operations ignore `recordEn`.
- R8: Layout: bit address b is `crOut[31-b]`, and field f is `crOut[31-4f -: 4]`. Within a field, bit 3 is LT (n0), bit 2 is GT, bit 1 is EQ and bit 0 is OV (n3). Bit 3 of `mask` and of `mode` governs LT, and bit 0 governs OV.
- R9: A bank write made by one operation is seen by an operation strobed in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| opSel | input | 2 | Operation select |
| mask | input | 4 | Per-bit selection mask |
| mode | input | 4 | Per-bit compare value |
| redOp | input | 2 | Reduction operator for integer result |
| anyMode | input | 1 | OR (1) or AND (0) for bit reduction |
| recordEn | input | 1 | Update field 0 from integer result |
| srcField | input | 3 | Source field address |
| dstAddr | input | 5 | Integer register, field (low 3 bits) or bit address |
| srcInt | input | 64 | Source integer |
| stickyOv | input | 1 | Sticky overflow copied by record |
| outValid | output | 1 | Result valid |
| outIntWe | output | 1 | Integer result write enable |
| outInt | output | 64 | Integer result |
| outDst | output | 5 | Destination address of the result |
| crOut | output | 32 | Whole condition bank |

## Verification
Field 0 can be read and written by the same operation: field 0 is the source of a recorded reduction, and the record overwrites it on the same edge. Separately, a field written in one cycle can be read by the operation strobed in the next. The bench provokes both on purpose. It records with `srcField`=0, and it chains back-to-back operations in which each reads the field or bit the previous one wrote. Every clock, the full bank and all result outputs are compared against a behavioural model. That model applies the reads of an operation before its writes.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int CFW = 4;

  typedef enum logic [1:0] {
    OP_F2I = 2'b00,
    OP_I2F = 2'b01,
    OP_F2F = 2'b10,
    OP_F2B = 2'b11
  } cmpOp_e;

  typedef enum logic [1:0] {
    RED_AND = 2'b00,
    RED_OR  = 2'b01,
    RED_XOR = 2'b10,
    RED_RSV = 2'b11
  } cmpRed_e;

  typedef struct packed {
    logic wrInt;
    logic wrField;
    logic wrBit;
    logic wrRec;
    logic fromInt;
  } cmpStrobe_t;
endpackage

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic       recordEn,
  output cmpStrobe_t strb
);
  cmpOp_e op;

  always_comb begin
    op           = cmpOp_e'(opSel);
    strb         = '0;
    strb.wrInt   = inValid && (op == OP_F2I);
    strb.wrRec   = inValid && (op == OP_F2I) && recordEn;
    strb.wrField = inValid && ((op == OP_I2F) || (op == OP_F2F));
    strb.fromInt = (op == OP_I2F);
    strb.wrBit   = inValid && (op == OP_F2B);
  end

  // R2: at most one kind of destination per operation
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrInt, strb.wrField, strb.wrBit}));

  // R7: record only goes with an integer result
  assert_rec_with_int_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRec |-> strb.wrInt);
endmodule

// File: rtl/cmp_dpath.sv
module cmp_dpath
  import cmp_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NFIELDS = 8,
  localparam int CRW    = NFIELDS * CFW,
  localparam int FA     = $clog2(NFIELDS),
  localparam int BA     = $clog2(CRW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  cmpStrobe_t      strb,
  input  logic [CFW-1:0]  mask,
  input  logic [CFW-1:0]  mode,
  input  logic [1:0]      redOp,
  input  logic            anyMode,
  input  logic [FA-1:0]   srcField,
  input  logic [BA-1:0]   dstAddr,
  input  logic [XLEN-1:0] srcInt,
  input  logic            stickyOv,
  output logic            outValid,
  output logic            outIntWe,
  output logic [XLEN-1:0] outInt,
  output logic [BA-1:0]   outDst,
  output logic [CRW-1:0]  crOut
);
  logic [CRW-1:0] crFile;
  logic [CRW-1:0] crNext;
  logic [CFW-1:0] fieldV [NFIELDS];
  logic [CFW-1:0] srcVal;
  logic [CFW-1:0] cmpRef;
  logic [CFW-1:0] cmpBits;
  logic           redBit;
  logic           bitRes;
  logic [XLEN-1:0] intRes;
  logic [CFW-1:0] recField;
  logic [FA-1:0]  dstField;

  for (genvar g = 0; g < NFIELDS; g++) begin : gField
    assign fieldV[g] = crFile[CRW-1-g*CFW -: CFW];
  end

  assign srcVal   = fieldV[srcField];
  assign dstField = dstAddr[FA-1:0];
  assign cmpRef   = strb.fromInt ? {CFW{srcInt[0]}} : srcVal;
  assign cmpBits  = mask & ~(mode ^ cmpRef);
  assign bitRes   = anyMode ? (|cmpBits) : (&cmpBits);

  always_comb begin
    unique case (cmpRed_e'(redOp))
      RED_AND: redBit = &(srcVal | ~mask);
      RED_OR:  redBit = |(srcVal & mask);
      RED_XOR: redBit = ^(srcVal & mask);
      default: redBit = 1'b0;
    endcase
  end

  assign intRes = {{(XLEN-1){1'b0}}, redBit};

  always_comb begin
    recField[3] = intRes[XLEN-1];
    recField[2] = !intRes[XLEN-1] && (intRes != '0);
    recField[1] = (intRes == '0);
    recField[0] = stickyOv;
  end

  always_comb begin
    crNext = crFile;
    if (strb.wrField) crNext[CRW-1-int'(dstField)*CFW -: CFW] = cmpBits;
    if (strb.wrBit)   crNext[CRW-1-int'(dstAddr)] = bitRes;
    if (strb.wrRec)   crNext[CRW-1 -: CFW] = recField;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crFile   <= '0;
      outValid <= 1'b0;
      outIntWe <= 1'b0;
      outInt   <= '0;
      outDst   <= '0;
    end else begin
      crFile   <= crNext;
      outValid <= inValid;
      outIntWe <= strb.wrInt;
      outInt   <= strb.wrInt ? intRes : '0;
      outDst   <= inValid ? dstAddr : '0;
    end
  end

  assign crOut = crFile;

  // R2: the result stage follows the strobe by one clock
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !outIntWe && $stable(crFile)));
  // R3: integer result is a single bit
  assert_int_onebit_R3: assert property (@(posedge clk) disable iff (!rstN)
    outIntWe |-> (outInt[XLEN-1:1] == '0));
  // R6: a bit write touches at most one bank bit
  assert_bit_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBit |=> ($countones(crFile ^ $past(crFile)) <= 1));
  // R7: record leaves exactly one of LT/GT/EQ set
  assert_rec_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRec |=> ($countones(crFile[CRW-1 -: 3]) == 1));
endmodule

// File: rtl/cond_mask_pred.sv
module cond_mask_pred
  import cmp_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NFIELDS = 8,
  localparam int CRW    = NFIELDS * CFW,
  localparam int FA     = $clog2(NFIELDS),
  localparam int BA     = $clog2(CRW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      opSel,
  input  logic [CFW-1:0]  mask,
  input  logic [CFW-1:0]  mode,
  input  logic [1:0]      redOp,
  input  logic            anyMode,
  input  logic            recordEn,
  input  logic [FA-1:0]   srcField,
  input  logic [BA-1:0]   dstAddr,
  input  logic [XLEN-1:0] srcInt,
  input  logic            stickyOv,
  output logic            outValid,
  output logic            outIntWe,
  output logic [XLEN-1:0] outInt,
  output logic [BA-1:0]   outDst,
  output logic [CRW-1:0]  crOut
);
  cmpStrobe_t strb;

  cmp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .recordEn(recordEn), .strb(strb)
  );

  cmp_dpath #(.XLEN(XLEN), .NFIELDS(NFIELDS)) dpath_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb),
    .mask(mask), .mode(mode), .redOp(redOp), .anyMode(anyMode),
    .srcField(srcField), .dstAddr(dstAddr), .srcInt(srcInt),
    .stickyOv(stickyOv), .outValid(outValid), .outIntWe(outIntWe),
    .outInt(outInt), .outDst(outDst), .crOut(crOut)
  );
endmodule

// File: tb/cond_mask_pred_tb.sv
module cond_mask_pred_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = '0;
  logic [3:0]  mask = '0;
  logic [3:0]  mode = '0;
  logic [1:0]  redOp = '0;
  logic        anyMode = 1'b0;
  logic        recordEn = 1'b0;
  logic [2:0]  srcField = '0;
  logic [4:0]  dstAddr = '0;
  logic [63:0] srcInt = '0;
  logic        stickyOv = 1'b0;
  logic        outValid, outIntWe;
  logic [63:0] outInt;
  logic [4:0]  outDst;
  logic [31:0] crOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] refCr = '0;
  logic        expValid = 0, expWe = 0;
  logic [63:0] expInt = '0;
  logic [4:0]  expDst = '0;

  always #5 clk = ~clk;

  cond_mask_pred dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .mask(mask),
    .mode(mode), .redOp(redOp), .anyMode(anyMode), .recordEn(recordEn),
    .srcField(srcField), .dstAddr(dstAddr), .srcInt(srcInt),
    .stickyOv(stickyOv), .outValid(outValid), .outIntWe(outIntWe),
    .outInt(outInt), .outDst(outDst), .crOut(crOut)
  );

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "outValid", 64'(outValid), 64'(expValid));
    chk(tag, "outIntWe", 64'(outIntWe), 64'(expWe));
    chk(tag, "outInt", outInt, expInt);
    chk(tag, "outDst", 64'(outDst), 64'(expDst));
    chk(tag, "crOut", 64'(crOut), 64'(refCr));
  endtask

  function automatic logic [3:0] getField(logic [31:0] cr, int f);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[3-i] = cr[31 - 4*f - i];
    return v;
  endfunction

  // model: reads first, then writes, result visible after next edge
  task automatic modelOp();
    logic [3:0] src, c;
    logic [31:0] nxt;
    int cnt, ones;
    logic r;
    nxt = refCr;
    expValid = inValid;
    expWe = 0;
    expInt = 0;
    expDst = inValid ? dstAddr : 5'd0;
    if (inValid) begin
      src = getField(refCr, int'(srcField));
      for (int i = 0; i < 4; i++) begin
        logic refBit;
        refBit = (opSel == 2'b01) ? srcInt[0] : src[i];
        c[i] = mask[i] && (mode[i] == refBit);
      end
      case (opSel)
        2'b00: begin
          cnt = 0; ones = 0;
          for (int i = 0; i < 4; i++) if (mask[i]) begin cnt++; if (src[i]) ones++; end
          if (redOp == 2'd0) r = (ones == cnt);
          else if (redOp == 2'd1) r = (ones > 0);
          else if (redOp == 2'd2) r = (ones % 2) == 1;
          else r = 0;
          expWe = 1;
          expInt = {63'd0, r};
          if (recordEn) begin
            nxt[31] = 1'b0;
            nxt[30] = r;
            nxt[29] = !r;
            nxt[28] = stickyOv;
          end
        end
        2'b01, 2'b10: begin
          for (int i = 0; i < 4; i++) nxt[31 - 4*int'(dstAddr[2:0]) - (3-i)] = c[i];
        end
        default: begin
          ones = 0;
          for (int i = 0; i < 4; i++) if (c[i]) ones++;
          r = anyMode ? (ones > 0) : (ones == 4);
          nxt[31 - int'(dstAddr)] = r;
        end
      endcase
    end
    refCr = nxt;
  endtask

  task automatic step(string tag, logic v, logic [1:0] op, logic [3:0] mk,
                      logic [3:0] md, logic [1:0] ro, logic am, logic rec,
                      logic [2:0] sf, logic [4:0] da, logic [63:0] si, logic so);
    inValid = v; opSel = op; mask = mk; mode = md; redOp = ro; anyMode = am;
    recordEn = rec; srcField = sf; dstAddr = da; srcInt = si; stickyOv = so;
    modelOp();
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");
    // R4: integer lsb into field 3, full and partial masks (R8 layout)
    step("R4", 1, 2'b01, 4'b1111, 4'b1010, 0, 0, 0, 0, 5'd3, 64'h1, 0);
    step("R4", 1, 2'b01, 4'b0110, 4'b1010, 0, 0, 0, 0, 5'd5, 64'hFFFF_FFFF_FFFF_FFFE, 0);
    step("R8", 1, 2'b01, 4'b1111, 4'b1000, 0, 0, 0, 0, 5'd7, 64'h1, 0);
    // R5 and R9: field to field chained on the just-written field
    step("R5", 1, 2'b10, 4'b1111, 4'b0000, 0, 0, 0, 3'd3, 5'd6, 64'h0, 0);
    step("R9", 1, 2'b10, 4'b1011, 4'b1111, 0, 0, 0, 3'd6, 5'd2, 64'h0, 0);
    // R3: every operator on field 3 (1010)
    step("R3", 1, 2'b00, 4'b1010, 0, 2'b00, 0, 0, 3'd3, 5'd9, 0, 0);
    step("R3", 1, 2'b00, 4'b1111, 0, 2'b00, 0, 0, 3'd3, 5'd9, 0, 0);
    step("R3", 1, 2'b00, 4'b0000, 0, 2'b00, 0, 0, 3'd3, 5'd9, 0, 0);
    step("R3", 1, 2'b00, 4'b0101, 0, 2'b01, 0, 0, 3'd3, 5'd10, 0, 0);
    step("R3", 1, 2'b00, 4'b1100, 0, 2'b01, 0, 0, 3'd3, 5'd10, 0, 0);
    step("R3", 1, 2'b00, 4'b1010, 0, 2'b10, 0, 0, 3'd3, 5'd11, 0, 0);
    step("R3", 1, 2'b00, 4'b1110, 0, 2'b10, 0, 0, 3'd3, 5'd11, 0, 0);
    step("R3", 1, 2'b00, 4'b1111, 0, 2'b11, 0, 0, 3'd3, 5'd12, 0, 0);
    // R7: record, also with field 0 as source in the same operation
    step("R7", 1, 2'b00, 4'b1010, 0, 2'b00, 0, 1, 3'd3, 5'd1, 0, 1);
    step("R7", 1, 2'b00, 4'b1111, 0, 2'b00, 0, 1, 3'd0, 5'd1, 0, 0);
    step("R7", 1, 2'b00, 4'b0010, 0, 2'b01, 0, 1, 3'd0, 5'd1, 0, 1);
    step("R7", 1, 2'b10, 4'b1111, 4'b0101, 0, 0, 1, 3'd3, 5'd4, 0, 1);
    // R6: bit reduction, OR and AND, then chained read (R9)
    step("R6", 1, 2'b11, 4'b0011, 4'b0000, 0, 1, 0, 3'd3, 5'd13, 0, 0);
    step("R6", 1, 2'b11, 4'b1111, 4'b1010, 0, 0, 0, 3'd3, 5'd0, 0, 0);
    step("R6", 1, 2'b11, 4'b1110, 4'b1010, 0, 0, 0, 3'd3, 5'd31, 0, 0);
    step("R9", 1, 2'b00, 4'b0100, 0, 2'b01, 0, 0, 3'd3, 5'd2, 0, 0);
    // R2: idle cycles with busy inputs
    step("R2", 0, 2'b01, 4'b1111, 4'b1111, 0, 1, 1, 3'd3, 5'd3, 64'h1, 1);
    step("R2", 0, 2'b11, 4'b1111, 4'b1111, 0, 1, 1, 3'd3, 5'd17, 64'h1, 1);
    // mixed traffic
    for (int n = 0; n < 300; n++) begin
      logic [63:0] rv;
      rv = {$urandom, $urandom};
      step("R9", rv[40], rv[1:0], rv[5:2], rv[9:6], rv[11:10], rv[12], rv[13],
           rv[16:14], rv[21:17], {63'd0, rv[22]}, rv[23]);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule